// File: doc/BRIEF.md
# Two-Phase 32-bit RISC Core

A compact 32-bit load/store processor core with separate instruction and data memory ports. Each instruction word uses the familiar six-field layout: opcode, two source register indices, a destination index, a shift amount and a function code. The core executes register and immediate arithmetic, a load-immediate form, word loads and stores, equality branches and an absolute jump. It has 32 general registers, all writable, including register 0. The program counter counts instruction words rather than bytes.

Every instruction completes in one clock period, split across the two clock edges. After a rising edge the new program counter addresses instruction memory, and the instruction is decoded combinationally. On the falling edge the decoded control and both register operands are captured. The ALU and data-memory access then settle during the low phase, and the next rising edge commits the result to the register file and to data memory and advances the program counter.

The memory ports carry no handshake. They use no valid/ready pair and have no stall path, so back-pressure cannot exist: the environment must return instruction words combinationally within the high phase and load data within the low phase. Data memory must accept a write on the rising edge whenever the write strobe is high.

Top module: `tp_risc_core`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high on a rising edge, the program counter becomes 0 and neither the register file nor data memory is written. Register contents survive reset unchanged.
- R2: Every instruction that is not a branch or a jump advances the program counter by exactly 1 per clock. Instruction memory is indexed by instruction number.
- R3: Opcode 0x0F (load-immediate) writes the zero-extended bits 15:0 into the register named by bits 25:21. For example, 0x3C200006 sets register 1 to 6.
- R4: Register 0 is an ordinary register: a value written to it reads back unchanged.
- R5: Opcode 0 performs the operation selected by funct on registers rs (25:21) and rt (20:16) and writes register rd (15:11). The funct codes are add 0x20, sub 0x22, and 0x24, or 0x25, xor 0x26, nor 0x27, signed set-less-than 0x2A, shift-left 0x00 and logical shift-right 0x02. The two shifts act on rt by bits 10:6.
- R6: Opcode 0x08 adds the sign-extended immediate to rs. Opcodes 0x0C and 0x0D AND and OR the zero-extended immediate with rs. All three write register rt.
- R7: Opcode 0x23 loads register rt from data word address rs + sign-extended immediate, truncated to the address width.
- R8: Opcode 0x2B writes register rt to data word address rs + sign-extended immediate, with `dmem_we` high for that one instruction.
- R9: Opcode 0x04 (equal) and opcode 0x05 (not equal) compare rs with rt. When the condition holds, the next program counter is PC+1 plus the sign-extended 16-bit offset; otherwise it is PC+1.
- R10: Opcode 0x02 loads the program counter with the low bits of instruction field 25:0.
- R11: Any other opcode, or an unlisted funct under opcode 0, writes nothing and only advances the program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; fetch and commit on rising edge, operand capture on falling edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| imem_addr | output | PC_W | Instruction word index (current program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | DA_W | Data word address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken by memory on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
The bench builds the core with an 8-bit program counter and an 8-bit data address, so both memories hold 256 words. At that size every random base-plus-offset address lands in the array, and address wrap-around occurs often. A random program of all operation classes runs in lockstep with an instruction-level model in the bench, so each branch outcome is compared through the program counter on every cycle. Directed programs pin down the worked load-immediate encodings, the writability of register 0, skipped and unskipped branch shadows, jump shadows, an unknown opcode, and register contents carried across a reset.

// File: rtl/tp_core_pkg.sv
package tp_core_pkg;
  localparam int XLEN      = 32;
  localparam int REG_IDX_W = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LDI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    K_NOP, K_ALU, K_LOAD, K_STORE, K_BEQ, K_BNE, K_JUMP
  } kind_e;

  typedef enum logic [3:0] {
    A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_NOR, A_SLT, A_SLL, A_SRL, A_PASSB
  } alu_e;

  typedef struct packed {
    kind_e                kind;
    alu_e                 alu;
    logic                 use_imm;
    logic                 wr_en;
    logic [REG_IDX_W-1:0] wr_idx;
    logic [XLEN-1:0]      imm;
    logic [4:0]           shamt;
  } ctrl_t;
endpackage

// File: rtl/tp_decode.sv
module tp_decode
  import tp_core_pkg::*;
(
  input  logic [XLEN-1:0]      instr,
  output ctrl_t                ctrl,
  output logic [REG_IDX_W-1:0] rs_idx,
  output logic [REG_IDX_W-1:0] rt_idx
);
  logic [5:0]      opc, fn;
  logic [XLEN-1:0] imm_s, imm_z;

  assign opc    = instr[31:26];
  assign fn     = instr[5:0];
  assign rs_idx = instr[25:21];
  assign rt_idx = instr[20:16];
  assign imm_s  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign imm_z  = {{(XLEN-16){1'b0}}, instr[15:0]};

  always_comb begin
    ctrl         = '0;
    ctrl.kind    = K_NOP;
    ctrl.alu     = A_ADD;
    ctrl.shamt   = instr[10:6];
    ctrl.wr_idx  = instr[20:16];
    case (opc)
      OP_RTYPE: begin
        ctrl.kind   = K_ALU;
        ctrl.wr_en  = 1'b1;
        ctrl.wr_idx = instr[15:11];
        case (fn)
          FN_ADD:  ctrl.alu = A_ADD;
          FN_SUB:  ctrl.alu = A_SUB;
          FN_AND:  ctrl.alu = A_AND;
          FN_OR:   ctrl.alu = A_OR;
          FN_XOR:  ctrl.alu = A_XOR;
          FN_NOR:  ctrl.alu = A_NOR;
          FN_SLT:  ctrl.alu = A_SLT;
          FN_SLL:  ctrl.alu = A_SLL;
          FN_SRL:  ctrl.alu = A_SRL;
          default: begin
            ctrl.kind  = K_NOP;
            ctrl.wr_en = 1'b0;
          end
        endcase
      end
      OP_ADDI, OP_ANDI, OP_ORI: begin
        ctrl.kind    = K_ALU;
        ctrl.wr_en   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.imm     = (opc == OP_ADDI) ? imm_s : imm_z;
        ctrl.alu     = (opc == OP_ADDI) ? A_ADD : (opc == OP_ANDI) ? A_AND : A_OR;
      end
      OP_LDI: begin
        ctrl.kind    = K_ALU;
        ctrl.wr_en   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.imm     = imm_z;
        ctrl.alu     = A_PASSB;
        ctrl.wr_idx  = instr[25:21];
      end
      OP_LW: begin
        ctrl.kind    = K_LOAD;
        ctrl.wr_en   = 1'b1;
        ctrl.use_imm = 1'b1;
        ctrl.imm     = imm_s;
      end
      OP_SW: begin
        ctrl.kind    = K_STORE;
        ctrl.use_imm = 1'b1;
        ctrl.imm     = imm_s;
      end
      OP_BEQ, OP_BNE: begin
        ctrl.kind = (opc == OP_BEQ) ? K_BEQ : K_BNE;
        ctrl.imm  = imm_s;
      end
      OP_JMP: begin
        ctrl.kind = K_JUMP;
        ctrl.imm  = {{(XLEN-26){1'b0}}, instr[25:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/tp_regfile.sv
module tp_regfile #(
  parameter int DW = 32,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] ra,
  output logic [DW-1:0] rb
);
  localparam int NREG = 1 << IW;

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (we && (widx == IW'(g))) regs[g] <= wdata;
    end
  end

  assign ra = regs[ra_idx];
  assign rb = regs[rb_idx];
endmodule

// File: rtl/tp_alu.sv
module tp_alu
  import tp_core_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_e          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [4:0]    shamt,
  output logic [DW-1:0] y
);
  always_comb begin
    case (op)
      A_ADD:   y = a + b;
      A_SUB:   y = a - b;
      A_AND:   y = a & b;
      A_OR:    y = a | b;
      A_XOR:   y = a ^ b;
      A_NOR:   y = ~(a | b);
      A_SLT:   y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      A_SLL:   y = b << shamt;
      A_SRL:   y = b >> shamt;
      A_PASSB: y = b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/tp_risc_core.sv
module tp_risc_core
  import tp_core_pkg::*;
#(
  parameter int PC_W = 10,
  parameter int DA_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [DA_W-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);
  logic [PC_W-1:0]      pc, pc_next, br_tgt;
  ctrl_t                d_ctrl, ex_ctrl;
  logic [REG_IDX_W-1:0] rs_idx, rt_idx;
  logic [XLEN-1:0]      rs_val, rt_val, ex_a, ex_b, alu_b, alu_y, wb_data;
  logic [PC_W-1:0]      ex_pc1;
  logic                 ex_valid, commit, taken, rf_we;

  assign imem_addr = pc;

  tp_decode u_dec (
    .instr (imem_rdata),
    .ctrl  (d_ctrl),
    .rs_idx(rs_idx),
    .rt_idx(rt_idx)
  );

  tp_regfile #(.DW(XLEN), .IW(REG_IDX_W)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .widx  (ex_ctrl.wr_idx),
    .wdata (wb_data),
    .ra_idx(rs_idx),
    .rb_idx(rt_idx),
    .ra    (rs_val),
    .rb    (rt_val)
  );

  // Falling-edge operand capture: the decoded word and its operands.
  always_ff @(negedge clk) begin
    ex_valid <= !rst;
    ex_ctrl  <= d_ctrl;
    ex_a     <= rs_val;
    ex_b     <= rt_val;
    ex_pc1   <= pc + PC_W'(1);
  end

  assign alu_b = ex_ctrl.use_imm ? ex_ctrl.imm : ex_b;

  tp_alu #(.DW(XLEN)) u_alu (
    .op   (ex_ctrl.alu),
    .a    (ex_a),
    .b    (alu_b),
    .shamt(ex_ctrl.shamt),
    .y    (alu_y)
  );

  assign commit     = ex_valid && !rst;
  assign wb_data    = (ex_ctrl.kind == K_LOAD) ? dmem_rdata : alu_y;
  assign rf_we      = commit && ex_ctrl.wr_en;
  assign dmem_addr  = alu_y[DA_W-1:0];
  assign dmem_wdata = ex_b;
  assign dmem_we    = commit && (ex_ctrl.kind == K_STORE);

  assign taken  = ((ex_ctrl.kind == K_BEQ) && (ex_a == ex_b)) ||
                  ((ex_ctrl.kind == K_BNE) && (ex_a != ex_b));
  assign br_tgt = ex_pc1 + ex_ctrl.imm[PC_W-1:0];

  always_comb begin
    if (!ex_valid)                   pc_next = pc;
    else if (ex_ctrl.kind == K_JUMP) pc_next = ex_ctrl.imm[PC_W-1:0];
    else if (taken)                  pc_next = br_tgt;
    else                             pc_next = ex_pc1;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> (pc == '0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && (ex_ctrl.kind inside {K_NOP, K_ALU, K_LOAD, K_STORE}))
    |=> (pc == PC_W'($past(pc) + PC_W'(1))));

  assert_ldi_zext_R3: assert property (@(posedge clk) disable iff (rst)
    (rf_we && (ex_ctrl.alu == A_PASSB)) |-> (wb_data[XLEN-1:16] == '0));

  assert_branch_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && (ex_ctrl.kind == K_BEQ) && (ex_a == ex_b))
    |=> (pc == $past(ex_pc1 + ex_ctrl.imm[PC_W-1:0])));

  assert_jump_target_R10: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && (ex_ctrl.kind == K_JUMP)) |=> (pc == $past(ex_ctrl.imm[PC_W-1:0])));
endmodule

// File: tb/tp_risc_core_tb_top.sv
module tp_risc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PCW = 8;
  localparam int DAW = 8;
  localparam int MEMN = 256;
  localparam logic [31:0] FILL = 32'hFC000000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [PCW-1:0] imem_addr;
  logic [31:0]    imem_rdata;
  logic [DAW-1:0] dmem_addr;
  logic [31:0]    dmem_wdata;
  logic           dmem_we;
  logic [31:0]    dmem_rdata;

  logic [31:0] imem   [MEMN];
  logic [31:0] dmem   [MEMN];
  logic [31:0] m_dmem [MEMN];
  logic [31:0] m_reg  [32];
  logic [PCW-1:0] m_pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tp_risc_core #(.PC_W(PCW), .DA_W(DAW)) dut_i (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_rdata(dmem_rdata)
  );

  assign imem_rdata = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  function automatic logic [31:0] f_r(input logic [5:0] fn, input int rs, input int rt,
                                      input int rd, input int sh);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] f_i(input logic [5:0] op, input int rs, input int rt,
                                      input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] f_li(input int rd, input logic [15:0] imm);
    return {6'h0F, 5'(rd), 5'd0, imm};
  endfunction
  function automatic logic [31:0] f_j(input int tgt);
    return {6'h02, 26'(tgt)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Instruction-level model of the requirements.
  task automatic iss_step();
    logic [31:0] in, a, b, si, zi;
    logic [PCW-1:0] nxt;
    in  = imem[m_pc];
    a   = m_reg[in[25:21]];
    b   = m_reg[in[20:16]];
    si  = {{16{in[15]}}, in[15:0]};
    zi  = {16'h0, in[15:0]};
    nxt = m_pc + PCW'(1);
    case (in[31:26])
      6'h00: case (in[5:0])
        6'h20: m_reg[in[15:11]] = a + b;
        6'h22: m_reg[in[15:11]] = a - b;
        6'h24: m_reg[in[15:11]] = a & b;
        6'h25: m_reg[in[15:11]] = a | b;
        6'h26: m_reg[in[15:11]] = a ^ b;
        6'h27: m_reg[in[15:11]] = ~(a | b);
        6'h2A: m_reg[in[15:11]] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'h00: m_reg[in[15:11]] = b << in[10:6];
        6'h02: m_reg[in[15:11]] = b >> in[10:6];
        default: ;
      endcase
      6'h08: m_reg[in[20:16]] = a + si;
      6'h0C: m_reg[in[20:16]] = a & zi;
      6'h0D: m_reg[in[20:16]] = a | zi;
      6'h0F: m_reg[in[25:21]] = zi;
      6'h23: m_reg[in[20:16]] = m_dmem[DAW'(a + si)];
      6'h2B: m_dmem[DAW'(a + si)] = b;
      6'h04: if (a == b) nxt = m_pc + PCW'(1) + si[PCW-1:0];
      6'h05: if (a != b) nxt = m_pc + PCW'(1) + si[PCW-1:0];
      6'h02: nxt = in[PCW-1:0];
      default: ;
    endcase
    m_pc = nxt;
  endtask

  // Lockstep run, entered and left at rising edge + 2.
  task automatic run(input int cycles, input string tag);
    int bad;
    for (int i = 0; i < cycles; i++) begin
      check({tag, " R2/R9/R10 pc"}, 32'(imem_addr), 32'(m_pc));
      iss_step();
      @(posedge clk); #2;
    end
    bad = 0;
    for (int i = 0; i < MEMN; i++) if (dmem[i] !== m_dmem[i]) bad++;
    check({tag, " R5-R8 data image mismatches"}, 32'(bad), 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    m_pc = '0;
    check("R1 pc after reset", 32'(imem_addr), 32'd0);
  endtask

  task automatic fill_imem();
    for (int i = 0; i < MEMN; i++) imem[i] = FILL;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int p;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MEMN; i++) begin dmem[i] = '0; m_dmem[i] = '0; end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    fill_imem();
    // Directed program A.
    imem[0]  = f_li(7, 16'h0011);
    imem[1]  = f_li(9, 16'h0022);
    imem[2]  = 32'h3C200006;            // r1 = 6
    imem[3]  = 32'h3C000005;            // r0 = 5
    imem[4]  = f_li(2, 16'hFFFF);
    imem[5]  = f_li(3, 16'h8000);
    imem[6]  = f_li(4, 16'h0000);
    imem[7]  = f_i(6'h2B, 4, 0, 16'd0);
    imem[8]  = f_i(6'h2B, 4, 1, 16'd1);
    imem[9]  = f_i(6'h2B, 4, 2, 16'd2);
    imem[10] = f_r(6'h20, 0, 1, 5, 0);
    imem[11] = f_r(6'h22, 0, 1, 6, 0);
    imem[12] = f_i(6'h2B, 4, 5, 16'd3);
    imem[13] = f_i(6'h2B, 4, 6, 16'd4);
    imem[14] = f_i(6'h04, 1, 1, 16'd1);
    imem[15] = f_li(7, 16'hDEAD);
    imem[16] = f_i(6'h05, 1, 1, 16'd1);
    imem[17] = f_li(8, 16'h0077);
    imem[18] = f_i(6'h2B, 4, 7, 16'd5);
    imem[19] = f_i(6'h2B, 4, 8, 16'd6);
    imem[20] = f_j(22);
    imem[21] = f_li(9, 16'h0BAD);
    imem[22] = f_i(6'h23, 4, 10, 16'd3);
    imem[23] = f_i(6'h2B, 4, 10, 16'd7);
    imem[24] = f_i(6'h2B, 4, 9, 16'd8);
    imem[25] = f_i(6'h2B, 4, 3, 16'd9);
    imem[26] = f_i(6'h3F, 1, 1, 16'h1234);
    imem[27] = f_i(6'h2B, 4, 1, 16'd12);
    imem[28] = f_i(6'h0C, 6, 11, 16'h00F0);
    imem[29] = f_i(6'h08, 0, 12, 16'hFFFE);
    imem[30] = f_i(6'h2B, 4, 11, 16'd13);
    imem[31] = f_i(6'h2B, 4, 12, 16'd14);
    imem[32] = f_j(32);
    @(posedge clk); #2;
    do_reset();
    run(45, "progA");
    check("R4 reg0 holds 5", dmem[0], 32'd5);
    check("R3 ldi 0x3C200006", dmem[1], 32'd6);
    check("R3 ldi zero-extend FFFF", dmem[2], 32'h0000FFFF);
    check("R3 ldi zero-extend 8000", dmem[9], 32'h00008000);
    check("R5 add", dmem[3], 32'd11);
    check("R5 sub", dmem[4], 32'hFFFFFFFF);
    check("R9 taken beq skips shadow", dmem[5], 32'h11);
    check("R9 untaken bne runs next", dmem[6], 32'h77);
    check("R7 load word", dmem[7], 32'd11);
    check("R10 jump skips shadow", dmem[8], 32'h22);
    check("R11 unknown opcode no write", dmem[12], 32'd6);
    check("R6 andi zero-extended", dmem[13], 32'h000000F0);
    check("R6 addi sign-extended", dmem[14], 32'd3);
    check("R2 pc parked on self-jump", 32'(imem_addr), 32'd32);

    // Program B: registers must survive reset.
    rst = 1'b1;
    fill_imem();
    imem[0] = f_li(4, 16'h0000);
    imem[1] = f_i(6'h2B, 4, 5, 16'd10);
    imem[2] = f_i(6'h2B, 4, 1, 16'd11);
    imem[3] = f_i(6'h2B, 4, 0, 16'd15);
    imem[4] = f_j(4);
    do_reset();
    run(8, "progB");
    check("R1 r5 kept over reset", dmem[10], 32'd11);
    check("R1 r1 kept over reset", dmem[11], 32'd6);
    check("R1 r0 kept over reset", dmem[15], 32'd5);

    // Program C: constrained random.
    rst = 1'b1;
    fill_imem();
    p = 0;
    for (int r = 0; r < 32; r++) begin imem[p] = f_li(r, 16'($urandom)); p++; end
    for (int k = 0; k < 80; k++) begin
      int sel = $urandom_range(0, 11);
      int rs = $urandom_range(0, 31);
      int rt = $urandom_range(0, 31);
      int rd = $urandom_range(0, 31);
      logic [15:0] im = 16'($urandom);
      case (sel)
        0, 1, 2, 3: begin
          logic [5:0] fl [9] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h00, 6'h02};
          imem[p] = f_r(fl[$urandom_range(0, 8)], rs, rt, rd, $urandom_range(0, 31));
        end
        4: imem[p] = f_i(6'h08, rs, rt, im);
        5: imem[p] = f_i(($urandom_range(0, 1) != 0) ? 6'h0C : 6'h0D, rs, rt, im);
        6: imem[p] = f_li(rd, im);
        7, 8: imem[p] = f_i(6'h2B, rs, rt, im);
        9: imem[p] = f_i(6'h23, rs, rt, im);
        10: imem[p] = f_i(($urandom_range(0, 1) != 0) ? 6'h04 : 6'h05,
                          rs, ($urandom_range(0, 3) == 0) ? rs : rt,
                          16'($urandom_range(0, 3)));
        default: imem[p] = f_r(6'h3F, rs, rt, rd, 0);
      endcase
      p++;
    end
    imem[p] = f_li(31, 16'h0000); p++;
    for (int r = 0; r < 31; r++) begin imem[p] = f_i(6'h2B, 31, r, 16'(200 + r)); p++; end
    imem[p] = f_j(p);
    do_reset();
    run(p + 10, "progC");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule